// File: doc/BRIEF.md
# Multi-Channel Digital Delay Pulse Generator

This block times pulses against a trigger by counting periods of a fast system clock. An accepted trigger opens a timing cycle. A reference output, `t0_out`, stays high for the whole cycle, and its first high clock period is tick 0 of the cycle. The block has four pulse channels by default. Each channel has a leading-edge delay and a trailing-edge delay, both counted in clock ticks from tick 0. The channel output is high from its leading tick up to, but not including, its trailing tick.

Each channel has its own trigger-rate divider, so it fires only on every Nth accepted cycle. Software loads the delays and dividers through a plain write port. Every cycle latches its own copy of the settings at its start, so writes made while a cycle runs apply only to the next cycle. An inhibit input blanks the pulse outputs at once and also refuses new triggers. The reference output is not affected by inhibit.

Top module: `delay_pulse_gen`

## Requirements
- R1: While reset is held, `t0_out` and all pulse outputs are low. Reset clears every delay register to 0 and sets every divider to 1. It also clears the divider counters, so the first accepted cycle after reset fires on all channels.
- R2: A trigger is accepted when `trig_in` is high, `inhibit_in` is low and no cycle is active, all sampled at a rising clock edge. `t0_out` goes high in the clock period that follows that edge, and that period is tick 0.
- R3: Channel c takes its leading delay from address 2c and its trailing delay from address 2c+1. When the channel fires and lead < trail, `pulse_out[c]` is high during every tick k with lead <= k < trail.
- R4: If a channel's trailing delay is less than or equal to its leading delay, the channel gives no pulse in that cycle. Such a channel does not count toward the cycle length.
- R5: `t0_out` stays high for E+1 ticks, where E is the largest trailing delay among the channels that fire with a valid pulse in that cycle. E is 0 when no channel qualifies.
- R6: Channel c takes its divider N from address 2*NUM_CH+c (low PSC_W bits of the write data). The channel fires on the first accepted cycle after reset and then on every Nth accepted cycle. N of 0 or 1 makes it fire on every cycle.
- R7: A trigger seen while a cycle is active, including on the cycle's last tick, is ignored. It neither restarts nor extends the cycle, and it does not start a new one afterwards.
- R8: A register write made during a cycle does not change that cycle's pulses or length. The next accepted cycle uses the new value.
- R9: While `inhibit_in` is high, every pulse output is low in the same clock period. `t0_out` is not affected.
- R10: A trigger presented while `inhibit_in` is high is not accepted and does not advance any divider.
- R11: A pulse output is never high while `t0_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; all timing counts its periods |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Trigger request, sampled on rising edges |
| inhibit_in | input | 1 | Blanks pulse outputs and refuses triggers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W ($clog2(3*NUM_CH)) | Write address: delays at 0..2*NUM_CH-1, dividers above them |
| wr_data | input | DLY_W | Write data (tick count, or divider in the low PSC_W bits) |
| t0_out | output | 1 | High for the full timing cycle |
| pulse_out | output | NUM_CH | One pulse output per channel |

## Verification
On every cycle, the checker confirms the following:
- the tick counter advances by exactly one while a cycle runs, so a trigger that arrives mid-cycle cannot restart it;
- the latched end tick stays frozen for the whole cycle;
- `t0_out` only falls on the end tick;
- `t0_out` only rises after an accepted trigger;
- no pulse appears outside `t0_out`.

Some properties need a reference computed from the programmed values, so only the bench scenarios show them. These are the exact pulse edges of each channel, the cycle length as the largest qualifying trailing delay, the divider firing pattern, the deferred effect of writes made mid-cycle, and the blanking by inhibit.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dpg_state_e;

   // Address of the leading (edge=0) or trailing (edge=1) delay of a channel
   function automatic int unsigned edge_addr(input int unsigned ch, input int unsigned edge_sel);
      return 2 * ch + edge_sel;
   endfunction

   // Address of a channel's divider, placed above all delay registers
   function automatic int unsigned div_addr(input int unsigned num_ch, input int unsigned ch);
      return 2 * num_ch + ch;
   endfunction

endpackage

// File: rtl/dpg_regs.sv
module dpg_regs #(
   parameter int NUM_CH = 4,
   parameter int DLY_W  = 32,
   parameter int PSC_W  = 16,
   parameter int ADDR_W = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [DLY_W-1:0]                   wr_data,
   output logic [2*NUM_CH-1:0][DLY_W-1:0]     dly_q,
   output logic [NUM_CH-1:0][PSC_W-1:0]       psc_q
);
   import dpg_pkg::*;

   localparam int NUM_DLY = 2 * NUM_CH;

   for (genvar i = 0; i < NUM_DLY; i++) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            dly_q[i] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
            dly_q[i] <= wr_data;
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_psc
      localparam int unsigned A = div_addr(NUM_CH, c);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            psc_q[c] <= PSC_W'(1);
         end else if (wr_en && (wr_addr == ADDR_W'(A))) begin
            psc_q[c] <= wr_data[PSC_W-1:0];
         end
      end
   end

endmodule

// File: rtl/dpg_chan.sv
module dpg_chan #(
   parameter int DLY_W = 32,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  logic [DLY_W-1:0] cnt,
   input  logic [DLY_W-1:0] lead_reg,
   input  logic [DLY_W-1:0] trail_reg,
   input  logic [PSC_W-1:0] psc_reg,
   output logic [DLY_W-1:0] end_req,
   output logic             pulse
);
   logic [PSC_W-1:0] pc_q;
   logic [PSC_W-1:0] pc_next;
   logic [PSC_W:0]   pc_inc;
   logic [DLY_W-1:0] lead_s;
   logic [DLY_W-1:0] trail_s;
   logic             arm_q;
   logic             will_fire;
   logic             span_ok;

   assign will_fire = (pc_q == '0);
   assign span_ok   = (lead_reg < trail_reg);
   assign end_req   = (will_fire && span_ok) ? trail_reg : '0;

   always_comb begin
      pc_inc  = {1'b0, pc_q} + 1'b1;
      pc_next = (pc_inc >= {1'b0, psc_reg}) ? '0 : pc_inc[PSC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         lead_s  <= '0;
         trail_s <= '0;
         arm_q   <= 1'b0;
      end else if (start) begin
         pc_q    <= pc_next;
         lead_s  <= lead_reg;
         trail_s <= trail_reg;
         arm_q   <= will_fire && span_ok;
      end
   end

   assign pulse = active && arm_q && (cnt >= lead_s) && (cnt < trail_s);

endmodule

// File: rtl/dpg_timer.sv
module dpg_timer #(
   parameter int DLY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             inhibit,
   input  logic [DLY_W-1:0] end_in,
   output logic             start,
   output logic             active,
   output logic [DLY_W-1:0] cnt,
   output logic [DLY_W-1:0] end_s
);
   import dpg_pkg::*;

   dpg_state_e state_q;

   assign active = (state_q == ST_RUN);
   assign start  = trig && !inhibit && (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt     <= '0;
         end_s   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  cnt     <= '0;
                  end_s   <= end_in;
               end
            end
            ST_RUN: begin
               if (cnt == end_s) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/delay_pulse_gen.sv
module delay_pulse_gen #(
   parameter int NUM_CH = 4,
   parameter int DLY_W  = 32,
   parameter int PSC_W  = 16,
   localparam int ADDR_W = $clog2(3 * NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_in,
   input  logic              inhibit_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DLY_W-1:0]  wr_data,
   output logic              t0_out,
   output logic [NUM_CH-1:0] pulse_out
);
   import dpg_pkg::*;

   if (NUM_CH < 1) begin : g_chk_ch
      $error("delay_pulse_gen: NUM_CH must be at least 1");
   end
   if (DLY_W < 2) begin : g_chk_dw
      $error("delay_pulse_gen: DLY_W must be at least 2");
   end
   if (PSC_W < 1 || PSC_W > DLY_W) begin : g_chk_pw
      $error("delay_pulse_gen: PSC_W must lie in 1..DLY_W");
   end

   logic [2*NUM_CH-1:0][DLY_W-1:0] dly_q;
   logic [NUM_CH-1:0][PSC_W-1:0]   psc_q;
   logic [NUM_CH-1:0][DLY_W-1:0]   end_req;
   logic [NUM_CH:0][DLY_W-1:0]     run_max;
   logic [NUM_CH-1:0]              pulse_raw;
   logic                           cyc_start;
   logic                           run_active;
   logic [DLY_W-1:0]               tick_cnt;
   logic [DLY_W-1:0]               end_tick;

   dpg_regs #(
      .NUM_CH (NUM_CH),
      .DLY_W  (DLY_W),
      .PSC_W  (PSC_W),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .dly_q   (dly_q),
      .psc_q   (psc_q)
   );

   dpg_timer #(
      .DLY_W (DLY_W)
   ) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig_in),
      .inhibit (inhibit_in),
      .end_in  (run_max[NUM_CH]),
      .start   (cyc_start),
      .active  (run_active),
      .cnt     (tick_cnt),
      .end_s   (end_tick)
   );

   assign run_max[0] = '0;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dpg_chan #(
         .DLY_W (DLY_W),
         .PSC_W (PSC_W)
      ) i_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .start     (cyc_start),
         .active    (run_active),
         .cnt       (tick_cnt),
         .lead_reg  (dly_q[edge_addr(c, 0)]),
         .trail_reg (dly_q[edge_addr(c, 1)]),
         .psc_reg   (psc_q[c]),
         .end_req   (end_req[c]),
         .pulse     (pulse_raw[c])
      );

      assign run_max[c+1] = (end_req[c] > run_max[c]) ? end_req[c] : run_max[c];
   end

   assign t0_out    = run_active;
   assign pulse_out = pulse_raw & {NUM_CH{~inhibit_in}};

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
   parameter int NUM_CH = 4,
   parameter int DLY_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_in,
   input logic              inhibit_in,
   input logic              t0_out,
   input logic [NUM_CH-1:0] pulse_out,
   input logic              active,
   input logic [DLY_W-1:0]  cnt,
   input logic [DLY_W-1:0]  end_s
);

   a_r2_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t0_out) |-> $past(trig_in && !inhibit_in));

   a_r7_count_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> (cnt == $past(cnt) + 1'b1));

   a_r8_end_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(end_s));

   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt <= end_s));

   a_r5_fall_on_end_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(t0_out) |-> $past(cnt == end_s));

   a_r11_pulse_inside_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_out != '0) |-> t0_out);

endmodule

bind delay_pulse_gen dpg_checker #(
   .NUM_CH (NUM_CH),
   .DLY_W  (DLY_W)
) i_dpg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_in    (trig_in),
   .inhibit_in (inhibit_in),
   .t0_out     (t0_out),
   .pulse_out  (pulse_out),
   .active     (run_active),
   .cnt        (tick_cnt),
   .end_s      (end_tick)
);

// File: tb/test_delay_pulse_gen.sv
module test_delay_pulse_gen;

   localparam int NCH = 4;
   localparam int DW  = 32;
   localparam int PW  = 16;
   localparam int AW  = $clog2(3 * NCH);
   localparam int RETRIG_LAST = 9999;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          trig_in;
   logic          inhibit_in;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic          t0_out;
   logic [NCH-1:0] pulse_out;

   always #2 clk = ~clk;

   delay_pulse_gen #(.NUM_CH(NCH), .DLY_W(DW), .PSC_W(PW)) i_delay_pulse_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_in    (trig_in),
      .inhibit_in (inhibit_in),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .t0_out     (t0_out),
      .pulse_out  (pulse_out)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int m_dly[2*NCH];
   int m_psc[NCH];
   int m_pc[NCH];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_write(input int a, input int d);
      if (a < 2 * NCH) m_dly[a] = d;
      else             m_psc[a - 2*NCH] = d;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = AW'(a);
      wr_data = DW'(d);
      @(negedge clk);
      wr_en   = 1'b0;
      model_write(a, d);
   endtask

   // One timing cycle with optional inhibit window, mid-cycle trigger and mid-cycle write
   task automatic run_cycle(input string tag, input int inh_from, input int inh_to,
                            input int retrig_at, input int wr_at, input int wa, input int wd);
      int ld[NCH];
      int tr[NCH];
      bit ok[NCH];
      int e = 0;
      int rt;
      for (int c = 0; c < NCH; c++) begin
         ld[c] = m_dly[2*c];
         tr[c] = m_dly[2*c+1];
         ok[c] = (m_pc[c] == 0) && (ld[c] < tr[c]);
         if (ok[c] && tr[c] > e) e = tr[c];
         m_pc[c] = (m_pc[c] + 1 >= m_psc[c]) ? 0 : m_pc[c] + 1;
      end
      rt = (retrig_at == RETRIG_LAST) ? e : retrig_at;
      @(negedge clk);
      trig_in = 1'b1;
      for (int k = 0; k <= e + 1; k++) begin
         @(negedge clk);
         trig_in    = (k == rt);
         inhibit_in = (k >= inh_from) && (k < inh_to);
         wr_en      = (k == wr_at);
         wr_addr    = AW'(wa);
         wr_data    = DW'(wd);
         if (k == wr_at) model_write(wa, wd);
         #1;
         chk(tag, "t0_out", int'(t0_out), int'(k <= e));
         for (int c = 0; c < NCH; c++) begin
            chk(tag, $sformatf("pulse_out[%0d] tick %0d", c, k), int'(pulse_out[c]),
                int'(ok[c] && k >= ld[c] && k < tr[c] && !inhibit_in && k <= e));
         end
      end
      @(negedge clk);
      trig_in    = 1'b0;
      inhibit_in = 1'b0;
      wr_en      = 1'b0;
      #1;
      chk(tag, "t0_out idle after cycle", int'(t0_out), 0);
   endtask

   initial begin
      rst_n      = 1'b0;
      trig_in    = 1'b0;
      inhibit_in = 1'b0;
      wr_en      = 1'b0;
      wr_addr    = '0;
      wr_data    = '0;
      for (int i = 0; i < 2*NCH; i++) m_dly[i] = 0;
      for (int c = 0; c < NCH; c++) begin m_psc[c] = 1; m_pc[c] = 0; end
      repeat (4) @(negedge clk);
      #1;
      // R1: reset state
      chk("R1", "t0_out in reset", int'(t0_out), 0);
      chk("R1", "pulse_out in reset", int'(pulse_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: zero delays -> no pulse, one-tick cycle
      run_cycle("R1", -1, -1, -1, -1, 0, 0);

      // R2: basic cycle with all channels programmed
      wr(0, 0); wr(1, 3);
      wr(2, 2); wr(3, 6);
      wr(4, 1); wr(5, 2);
      wr(6, 4); wr(7, 5);
      run_cycle("R2", -1, -1, -1, -1, 0, 0);

      // R3/R4: sweep channel 0 edges, other channels fixed
      for (int l = 0; l < 4; l++) begin
         for (int t = 0; t < 9; t += 2) begin
            wr(0, l); wr(1, t);
            run_cycle((l < t) ? "R3" : "R4", -1, -1, -1, -1, 0, 0);
         end
      end

      // R4: all channels invalid, cycle collapses to one tick
      wr(0, 5); wr(1, 5); wr(2, 7); wr(3, 3); wr(4, 2); wr(5, 1); wr(6, 4); wr(7, 4);
      run_cycle("R4", -1, -1, -1, -1, 0, 0);

      // R5: longest channel sets the length
      wr(0, 1); wr(1, 2); wr(2, 0); wr(3, 11); wr(4, 3); wr(5, 7); wr(6, 2); wr(7, 4);
      run_cycle("R5", -1, -1, -1, -1, 0, 0);

      // R6: divider sweep, including 0 meaning every cycle
      wr(8, 2); wr(9, 3); wr(10, 4); wr(11, 0);
      for (int n = 0; n < 12; n++) run_cycle("R6", -1, -1, -1, -1, 0, 0);
      wr(8, 1); wr(9, 1); wr(10, 1); wr(11, 1);
      for (int n = 0; n < 3; n++) run_cycle("R6", -1, -1, -1, -1, 0, 0);

      // R7: triggers during an active cycle, including its last tick
      run_cycle("R7", -1, -1, 2, -1, 0, 0);
      run_cycle("R7", -1, -1, RETRIG_LAST, -1, 0, 0);

      // R8: write mid-cycle, applies to the next cycle only
      run_cycle("R8", -1, -1, -1, 1, 3, 15);
      run_cycle("R8", -1, -1, -1, 3, 2, 9);
      run_cycle("R8", -1, -1, -1, -1, 0, 0);

      // R9: inhibit blanks pulses, t0 unaffected
      wr(2, 0); wr(3, 8);
      run_cycle("R9", 1, 4, -1, -1, 0, 0);
      run_cycle("R9", 0, 9, -1, -1, 0, 0);

      // R10: inhibited trigger refused and divider not advanced
      wr(8, 2);
      run_cycle("R10", -1, -1, -1, -1, 0, 0);
      @(negedge clk);
      trig_in    = 1'b1;
      inhibit_in = 1'b1;
      @(negedge clk);
      trig_in    = 1'b0;
      inhibit_in = 1'b0;
      #1;
      chk("R10", "t0_out after inhibited trigger", int'(t0_out), 0);
      run_cycle("R10", -1, -1, -1, -1, 0, 0);
      run_cycle("R10", -1, -1, -1, -1, 0, 0);

      // R11 is covered per tick: every pulse check also requires k <= e (t0 high)
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule